// File: doc/BRIEF.md
# Self-Advancing Word Column

A storage column of `DEPTH` locations, each `WIDTH` bits wide, that moves every word toward the output end without any read or write pointers. Each location has one occupancy bit. On every clock a word steps down one location if the location below is empty, or is being emptied in that same cycle. A word written at the top therefore drifts to the bottom by itself and waits behind any word that is already queued there.

The write side sees one status bit, `top_empty`, and may present a word on `wr_data` with `wr_en`. The word is taken only while the top location is free. The read side sees the bottom word on `rd_data`, qualified by `bottom_valid`, and removes it with a one-cycle `rd_take`. The column is synchronous: a location changes at most once per clock. Reset clears the occupancy bits only. The stored data bits keep their values.

Top module: `fallthru_stack`

## Requirements
- R1: After reset, `top_empty` is 1 and `bottom_valid` is 0.
- R2: A write (`wr_en`=1 at a rising edge) is accepted only when `top_empty` is 1 at that edge. After an accepted write, `top_empty` is 0 on the next cycle. A write while `top_empty` is 0 adds no word.
- R3: A word advances one location per clock while the location below is free. A word written into an empty column raises `bottom_valid` on the 61st rising edge after the edge that accepted it, and not before.
- R4: Words leave in the order they were accepted. No word is lost, duplicated or overwritten.
- R5: With no takes, exactly `DEPTH` (62) writes are accepted. `top_empty` then stays 0.
- R6: `rd_take`=1 while `bottom_valid` is 1 removes the bottom word. `rd_take` while `bottom_valid` is 0 changes nothing.
- R7: A take empties the bottom location, and the word above moves into it on the same edge. From a full column, a take on each of 62 consecutive edges delivers all 62 words back to back, with `bottom_valid` staying 1 throughout.
- R8: While `bottom_valid` is 1 and no take occurs, `rd_data` and `bottom_valid` hold, even while later words queue behind it.
- R9: Reset clears all occupancy, which discards queued words. It does not alter stored data. `rd_data` always shows the bits held in the bottom location, so it keeps its value across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of occupancy bits |
| wr_en | input | 1 | Write request for the top location |
| wr_data | input | WIDTH | Word to write |
| top_empty | output | 1 | Top location is free; a write will be accepted |
| rd_take | input | 1 | Remove the bottom word |
| rd_data | output | WIDTH | Bits stored in the bottom location |
| bottom_valid | output | 1 | Bottom location holds a word |

## Verification
A wrong occupancy bit shows up at the ports in one of two ways. A location marked full that holds no word adds a phantom word. A location marked empty that holds a word drops that word. In both cases the drained sequence differs from the written one, and the error is seen within one transit of the column, at most 61 cycles. A wrong move decision shows up sooner. A word that is overwritten or copied appears as a missing or repeated value at the bottom. A failure to move on a vacated slot breaks back-to-back delivery from a full column in the very next cycle. A latency that is off by one is caught by sampling `bottom_valid` at the 60th and 61st edges after a lone write.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int unsigned FTS_WIDTH = 4;
    localparam int unsigned FTS_DEPTH = 62;

    // Per-location move command issued by the controller.
    typedef struct packed {
        logic load;    // capture the word from above (or the write port)
        logic vacate;  // current word leaves this location
    } fts_move_t;

endpackage

// File: rtl/fts_cell.sv
module fts_cell
    import fts_pkg::*;
#(
    parameter int unsigned WIDTH = FTS_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fts_move_t        mv,
    input  logic [WIDTH-1:0] din,
    output logic             occ,
    output logic [WIDTH-1:0] data
);

    typedef struct packed {
        logic             occ;
        logic [WIDTH-1:0] data;
    } cell_t;

    cell_t            c_d;
    logic             occ_q;
    logic [WIDTH-1:0] data_q;

    always_comb begin
        c_d.occ  = occ_q;
        c_d.data = data_q;
        if (mv.load) begin
            c_d.occ  = 1'b1;
            c_d.data = din;
        end else if (mv.vacate) begin
            c_d.occ  = 1'b0;
        end
    end

    // Occupancy is the only reset state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= 1'b0;
        else        occ_q <= c_d.occ;
    end

    // Data bits survive reset.
    always_ff @(posedge clk) begin
        data_q <= c_d.data;
    end

    assign occ  = occ_q;
    assign data = data_q;

    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q && !mv.vacate && !mv.load |=> occ_q && $stable(data_q)); // R8

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mv.load |-> (!occ_q || mv.vacate)); // R4

endmodule

// File: rtl/fts_ctrl.sv
module fts_ctrl
    import fts_pkg::*;
#(
    parameter int unsigned DEPTH = FTS_DEPTH
) (
    input  logic [DEPTH-1:0] occ,
    input  logic             wr_en,
    input  logic             rd_take,
    output logic [DEPTH-1:0] load,
    output logic [DEPTH-1:0] vacate,
    output logic             push_ok,
    output logic             pop_ok
);

    localparam int unsigned LAST = DEPTH - 1;

    // Decisions ripple from the bottom upward: a location may accept a
    // word when it is free or is being emptied in the same cycle.
    always_comb begin
        load       = '0;
        vacate     = '0;
        pop_ok     = occ[LAST] & rd_take;
        vacate[LAST] = pop_ok;
        for (int i = LAST; i >= 1; i--) begin
            load[i]     = occ[i-1] & (~occ[i] | vacate[i]);
            vacate[i-1] = load[i];
        end
        // The write port only fills a top location that is already empty.
        push_ok = wr_en & ~occ[0];
        load[0] = push_ok;
    end

endmodule

// File: rtl/fallthru_stack.sv
module fallthru_stack
    import fts_pkg::*;
#(
    parameter int unsigned WIDTH = FTS_WIDTH,
    parameter int unsigned DEPTH = FTS_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             top_empty,
    input  logic             rd_take,
    output logic [WIDTH-1:0] rd_data,
    output logic             bottom_valid
);

    localparam int unsigned LAST = DEPTH - 1;

    logic [DEPTH-1:0] occ;
    logic [DEPTH-1:0] load;
    logic [DEPTH-1:0] vacate;
    logic             push_ok;
    logic             pop_ok;
    logic [WIDTH-1:0] cell_data [DEPTH];

    fts_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .occ     (occ),
        .wr_en   (wr_en),
        .rd_take (rd_take),
        .load    (load),
        .vacate  (vacate),
        .push_ok (push_ok),
        .pop_ok  (pop_ok)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [WIDTH-1:0] din_w;
        fts_move_t        mv_w;

        if (i == 0) begin : g_top
            assign din_w = wr_data;
        end else begin : g_mid
            assign din_w = cell_data[i-1];
        end

        assign mv_w.load   = load[i];
        assign mv_w.vacate = vacate[i];

        fts_cell #(.WIDTH(WIDTH)) i_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mv    (mv_w),
            .din   (din_w),
            .occ   (occ[i]),
            .data  (cell_data[i])
        );
    end

    assign top_empty    = ~occ[0];
    assign bottom_valid = occ[LAST];
    assign rd_data      = cell_data[LAST];

    AST_WORD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(occ) ==
            $past($countones(occ)) + int'($past(push_ok)) - int'($past(pop_ok)))); // R4

    AST_WRITE_FILLS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && top_empty |=> !top_empty); // R2

    AST_BOTTOM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        bottom_valid && !rd_take |=> bottom_valid && $stable(rd_data)); // R8

    AST_EMPTY_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take && !bottom_valid && !wr_en |=> $countones(occ) == $past($countones(occ))); // R6

endmodule

// File: tb/test_fallthru_stack.sv
module test_fallthru_stack;

    localparam int W = 4;
    localparam int D = 62;

    typedef struct packed {
        logic [3:0] word;
        logic [3:0] hold;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{word: 4'h3, hold: 4'd0}, '{word: 4'hE, hold: 4'd2},
        '{word: 4'h0, hold: 4'd1}, '{word: 4'hF, hold: 4'd0},
        '{word: 4'h7, hold: 4'd5}, '{word: 4'h7, hold: 4'd0},
        '{word: 4'h8, hold: 4'd3}, '{word: 4'h1, hold: 4'd0},
        '{word: 4'hA, hold: 4'd4}, '{word: 4'h5, hold: 4'd1}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [W-1:0] wr_data;
    logic         top_empty;
    logic         rd_take;
    logic [W-1:0] rd_data;
    logic         bottom_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fallthru_stack #(.WIDTH(W), .DEPTH(D)) i_fallthru_stack (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .top_empty    (top_empty),
        .rd_take      (rd_take),
        .rd_data      (rd_data),
        .bottom_valid (bottom_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at a negedge.
    task automatic push(input logic [3:0] w);
        int t = 0;
        while (!top_empty && t < 500) begin
            @(negedge clk);
            t++;
        end
        chk(top_empty, "R2 push space", int'(top_empty), 1);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_valid();
        int t = 0;
        while (!bottom_valid && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk(bottom_valid, "R3 arrival", int'(bottom_valid), 1);
    endtask

    task automatic take();
        rd_take = 1'b1;
        @(negedge clk);
        rd_take = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int acc;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        rd_take = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(top_empty == 1'b1, "R1 top_empty", int'(top_empty), 1);
        chk(bottom_valid == 1'b0, "R1 bottom_valid", int'(bottom_valid), 0);

        // Table walk: R4 order, R8 hold while idle
        foreach (VEC[i]) push(VEC[i].word);
        foreach (VEC[i]) begin
            wait_valid();
            for (int h = 0; h < int'(VEC[i].hold); h++) begin
                @(negedge clk);
                chk(bottom_valid && rd_data == VEC[i].word, "R8 hold",
                    int'(rd_data), int'(VEC[i].word));
            end
            chk(rd_data == VEC[i].word, "R4 order", int'(rd_data), int'(VEC[i].word));
            take();
        end
        repeat (80) @(negedge clk);
        chk(bottom_valid == 1'b0, "R4 no duplicate", int'(bottom_valid), 0);

        // R3 transit latency through an empty column
        wr_en   = 1'b1;
        wr_data = 4'h6;
        @(negedge clk);
        wr_en   = 1'b0;
        repeat (60) @(negedge clk);
        chk(bottom_valid == 1'b0, "R3 edge 60", int'(bottom_valid), 0);
        @(negedge clk);
        chk(bottom_valid == 1'b1, "R3 edge 61", int'(bottom_valid), 1);
        chk(rd_data == 4'h6, "R3 data", int'(rd_data), 6);
        take();
        chk(bottom_valid == 1'b0, "R6 take removes", int'(bottom_valid), 0);

        // R6 take on an empty column is ignored
        take();
        chk(bottom_valid == 1'b0, "R6 empty take valid", int'(bottom_valid), 0);
        chk(top_empty == 1'b1, "R6 empty take top", int'(top_empty), 1);
        push(4'h9);
        wait_valid();
        chk(rd_data == 4'h9, "R6 after empty take", int'(rd_data), 9);
        take();
        chk(bottom_valid == 1'b0, "R6 single word gone", int'(bottom_valid), 0);

        // R8 bottom holds while another word queues; R7 refill on take
        push(4'hA);
        wait_valid();
        push(4'h5);
        repeat (70) @(negedge clk);
        chk(bottom_valid && rd_data == 4'hA, "R8 bottom kept", int'(rd_data), 10);
        take();
        chk(bottom_valid == 1'b1, "R7 refill valid", int'(bottom_valid), 1);
        chk(rd_data == 4'h5, "R7 refill data", int'(rd_data), 5);
        take();
        chk(bottom_valid == 1'b0, "R6 drained", int'(bottom_valid), 0);

        // R5 capacity, R2 writes while full ignored
        acc   = 0;
        wr_en = 1'b1;
        for (int c = 0; c < 400; c++) begin
            wr_data = acc[3:0];
            if (top_empty) acc++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk(acc == D, "R5 accepted", acc, D);
        chk(top_empty == 1'b0, "R5 full", int'(top_empty), 0);

        // R7 back-to-back drain from full
        for (int k = 0; k < D; k++) begin
            chk(bottom_valid == 1'b1, "R7 stream valid", int'(bottom_valid), 1);
            chk(rd_data == k[3:0], "R7 stream data", int'(rd_data), k % 16);
            rd_take = 1'b1;
            @(negedge clk);
        end
        rd_take = 1'b0;
        chk(bottom_valid == 1'b0, "R2 no extra word", int'(bottom_valid), 0);
        chk(top_empty == 1'b1, "R7 empty after drain", int'(top_empty), 1);

        // R9 reset clears occupancy but not stored bits
        push(4'hC);
        wait_valid();
        push(4'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(top_empty == 1'b1, "R9 top cleared", int'(top_empty), 1);
        chk(bottom_valid == 1'b0, "R9 bottom cleared", int'(bottom_valid), 0);
        chk(rd_data == 4'hC, "R9 data kept", int'(rd_data), 12);
        rst_n = 1'b1;
        repeat (70) @(negedge clk);
        chk(bottom_valid == 1'b0, "R9 queued word discarded", int'(bottom_valid), 0);
        chk(rd_data == 4'hC, "R9 data still kept", int'(rd_data), 12);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule